// File: doc/BRIEF.md
# Clock-Synchronized Serial Shift Port

This block is an eight-bit serial shifter for a peripheral-interface device. All of its logic runs on the system clock. It moves one byte at a time over a serial data pin. The direction is set by a control bit: bits are taken in from the pin, or presented on it. The shift clock comes from one of three sources:

- an external, asynchronous clock pin, so the partner device is the clock master;
- a locally generated clock whose half-period is set by a divider register, driven out so this unit is the master;
- a fast local clock that moves one bit every two system-clock cycles.

The external shift clock never reaches the edge logic directly. It first passes through a synchronizing register chain on the system clock, then through a previous-value register. Every transition is therefore seen as a clean one-cycle event, and none is lost when it lands close to a system-clock edge.

Both the external and the local clock act the same way. A falling shift-clock edge moves the register one place toward the MSB and takes the synchronized data pin into the LSB. A rising edge updates the serial output bit to the current MSB. A bit counter sets a byte-complete flag on the eighth shift. In the local modes the clock is then parked high until software reads or writes the data register. An optional handshake output mirrors the flag to the partner device. A small register port with four addresses gives software access to data, control, divider and status.

Top module: `sync_shift_port`

## Requirements
- R1: After a synchronous active-low reset, all of the following hold: sclk_out is 1, sdata_out is 0, byte_done is 0, hs_out is 0, and the data, control and divider registers read 0.
- R2: In external mode (control bits [1:0] = 01), each falling edge of sclk_in shifts exactly one bit. The shift lands on the second system-clock rising edge after the first edge that samples sclk_in low.
- R3: Each shift moves the register left by one place. The LSB takes the value of sdata_in delayed by two system-clock registers. After eight shifts, the first bit received is bit 7 of the data register (address 0).
- R4: A write to address 0 puts wdata bit 7 on sdata_out at once. On each rising shift-clock event, sdata_out takes the register's current bit 7. The byte therefore leaves MSB first, and each bit is valid across its falling edge.
- R5: byte_done, which reads as status bit 0 at address 3, goes to 1 on the eighth shift after the last data-register access.
- R6: Any read or write of address 0 clears byte_done and restarts the bit count at zero.
- R7: In fast mode (control bits [1:0] = 11), a data-register access starts sclk_out toggling on every system clock. This gives one bit per two cycles.
- R8: In timer mode (control bits [1:0] = 10), each half-period of sclk_out lasts (divider + 1) system clocks. The divider is at address 2.
- R9: In the local modes, the clock stops high after eight bits and stays high until the next data-register access. In external mode, shifting continues past eight bits and byte_done stays set.
- R10: sclk_oe is 1 exactly in the local modes. sdata_oe equals control bit 2 (1 means shift out).
- R11: hs_out is byte_done ANDed with control bit 3.
- R12: In off mode (control bits [1:0] = 00), edges on sclk_in leave the data register unchanged.
- R13: A symmetric external clock with a period of six system clocks receives a full byte without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 divider, 3 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 0 has side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sclk_in | input | 1 | External asynchronous shift clock |
| sclk_out | output | 1 | Locally generated shift clock, idles high |
| sclk_oe | output | 1 | Drive enable for sclk_out |
| sdata_in | input | 1 | Serial data in |
| sdata_out | output | 1 | Serial data out |
| sdata_oe | output | 1 | Drive enable for sdata_out |
| byte_done | output | 1 | Byte-complete flag |
| hs_out | output | 1 | Handshake line to the partner device |

## Verification
- **Reception patterns.** External reception is tried with bytes whose bit patterns alternate and also run in blocks (A5, 3C, C3). A dropped or doubled edge therefore shows up as a wrong value, not a lucky match.
- **Count behaviour.** A partial byte followed by a data access separates a counter that restarts from one that does not. Extra bits sent after the flag expose a wrong external-mode stop.
- **Local modes.** Transmission in fast mode and in divided mode is captured at every falling edge of sclk_out. This checks the MSB-first order, the number of edges and the half-period length together.
- **Off mode and cycle model.** A burst of edges in off mode shows that the register stays untouched. A cycle-level model checks every output on every clock, which pins down the synchronizer latency exactly.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial shift port: clock-source modes, register
// addresses and the packed control-register layout.
package ssr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_EXT   = 2'd1,
        MODE_TIMER = 2'd2,
        MODE_FAST  = 2'd3
    } shift_mode_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    // bit 3 handshake enable, bit 2 direction (1 = out), bits 1:0 mode
    typedef struct packed {
        logic        hs_en;
        logic        dir_out;
        shift_mode_e mode;
    } ctrl_t;
endpackage

// File: rtl/ssr_sync.sv
`timescale 1ns/1ps
// ssr_sync: multi-flop synchronizer for an asynchronous single-bit input.
// Assumes STAGES >= 2; the reset value is chosen to match the input's idle level.
module ssr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the asynchronous level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ssr_ext_edge.sv
`timescale 1ns/1ps
// ssr_ext_edge: registers the external shift clock on the system clock and turns
// its transitions into one-cycle fall/rise events. Assumes the pin idles high.
module ssr_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall_ev,
    output logic rise_ev
);
    logic cur, prev;

    ssr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin), .q(cur)
    );

    // Keep a delayed copy of the synchronized clock for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= cur;
    end

    assign fall_ev = prev & ~cur;
    assign rise_ev = ~prev & cur;

    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev |=> !fall_ev);
endmodule

// File: rtl/ssr_clkgen.sv
`timescale 1ns/1ps
// ssr_clkgen: local shift-clock source. Toggles every (limit+1) cycles while
// running, idles high, stops after the rise that follows a completed byte.
// restart has priority and suppresses that cycle's events.
module ssr_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             arm,
    input  logic             done_i,
    input  logic [DIV_W-1:0] limit,
    output logic             sclk,
    output logic             fall_ev,
    output logic             rise_ev
);
    logic             run;
    logic [DIV_W-1:0] tcnt;
    logic             tick;

    assign tick    = run && (tcnt == limit) && !restart;
    assign fall_ev = tick && sclk;
    assign rise_ev = tick && !sclk;

    // Half-period counter, clock level and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            sclk <= 1'b1;
            tcnt <= '0;
        end else if (restart) begin
            run  <= arm;
            sclk <= 1'b1;
            tcnt <= '0;
        end else if (tick) begin
            if (!sclk && done_i) run <= 1'b0;
            sclk <= ~sclk;
            tcnt <= '0;
        end else if (run) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> sclk);
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !restart) |=> $stable(sclk));
endmodule

// File: rtl/ssr_core.sv
`timescale 1ns/1ps
// ssr_core: the shift register, bit counter, byte-complete flag and output bit.
// A data-register access has priority over any shift event in the same cycle.
module ssr_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         shift_ev,
    input  logic         upd_ev,
    input  logic         sin,
    output logic [W-1:0] sr,
    output logic         done,
    output logic         sout
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;

    // Load/clear on access, otherwise shift in MSB-first and count bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            cnt  <= '0;
            done <= 1'b0;
            sout <= 1'b0;
        end else if (acc) begin
            if (wr) begin
                sr   <= wdata;
                sout <= wdata[W-1];
            end
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            if (shift_ev) begin
                sr  <= {sr[W-2:0], sin};
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                if (cnt == LAST) done <= 1'b1;
            end
            if (upd_ev) sout <= sr[W-1];
        end
    end

    a_r6_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (!done && cnt == '0));
    a_r5_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && shift_ev && cnt == LAST) |=> done);
    a_r2_count_only_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !shift_ev) |=> ($stable(cnt) && $stable(sr)));
endmodule

// File: rtl/sync_shift_port.sv
`timescale 1ns/1ps
// sync_shift_port: top level. Register port, clock-source selection and
// wiring of the synchronizers, local clock generator and shift core.
// Assumes DIV_W <= DATA_W and DATA_W >= 4.
module sync_shift_port
    import ssr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdata_in,
    output logic              sdata_out,
    output logic              sdata_oe,
    output logic              byte_done,
    output logic              hs_out
);
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  limit;
    logic [DATA_W-1:0] sr_q;
    logic acc, cwr, internal;
    logic ext_fall, ext_rise, int_fall, int_rise;
    logic sin_s, shift_ev, upd_ev;

    assign acc      = (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
    assign cwr      = bus_wr && (bus_addr == ADDR_CTRL);
    assign internal = ctrl_q.mode[1];
    assign limit    = (ctrl_q.mode == MODE_FAST) ? '0 : div_q;

    // Control and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(4'd0);
            div_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(bus_wdata[3:0]);
            if (bus_addr == ADDR_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    ssr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(sclk_in),
        .fall_ev(ext_fall), .rise_ev(ext_rise)
    );

    ssr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din (
        .clk(clk), .rst_n(rst_n), .d(sdata_in), .q(sin_s)
    );

    ssr_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n),
        .restart(acc || cwr), .arm(acc && internal), .done_i(byte_done),
        .limit(limit), .sclk(sclk_out),
        .fall_ev(int_fall), .rise_ev(int_rise)
    );

    // Pick the event source for the active clock mode.
    always_comb begin
        shift_ev = 1'b0;
        upd_ev   = 1'b0;
        if (ctrl_q.mode == MODE_EXT) begin
            shift_ev = ext_fall;
            upd_ev   = ext_rise;
        end else if (internal) begin
            shift_ev = int_fall;
            upd_ev   = int_rise;
        end
    end

    ssr_core #(.W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .acc(acc), .wr(bus_wr), .wdata(bus_wdata),
        .shift_ev(shift_ev), .upd_ev(upd_ev), .sin(sin_s),
        .sr(sr_q), .done(byte_done), .sout(sdata_out)
    );

    // Register read multiplexer.
    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = sr_q;
            ADDR_CTRL: bus_rdata = {{(DATA_W-4){1'b0}}, ctrl_q};
            ADDR_DIV:  bus_rdata = DATA_W'(div_q);
            default:   bus_rdata = {{(DATA_W-1){1'b0}}, byte_done};
        endcase
    end

    assign sclk_oe  = internal;
    assign sdata_oe = ctrl_q.dir_out;
    assign hs_out   = byte_done && ctrl_q.hs_en;

    a_r11_hs_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        hs_out |-> byte_done);
    a_r12_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode == MODE_OFF && !acc) |=> $stable(sr_q));
endmodule

// File: tb/sync_shift_port_bench.sv
`timescale 1ns/1ps
module sync_shift_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] baddr = 2'd0;
    logic       bwr = 1'b0, brd = 1'b0;
    logic [7:0] bwd = 8'd0;
    logic [7:0] brdata;
    logic       sclk_in_drv = 1'b1, sdi = 1'b0;
    logic       sclk_out, sclk_oe, sdata_out, sdata_oe, byte_done, hs_out;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sync_shift_port u_sync_shift_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(baddr), .bus_wr(bwr), .bus_rd(brd),
        .bus_wdata(bwd), .bus_rdata(brdata), .sclk_in(sclk_in_drv),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata_in(sdi),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .byte_done(byte_done),
        .hs_out(hs_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit pq[$];
    bit dq[$];
    logic [7:0] e_sr, e_div;
    logic [1:0] e_mode;
    bit e_dir, e_hs, e_done, e_out, e_iclk, e_run;
    int e_cnt, e_tc;

    always @(posedge clk) begin
        bit p2, p3, d2, fe, re, acc, cwr, tick, sh, up, old;
        int lim;
        if (!rst_n) begin
            pq.delete(); dq.delete();
            e_sr = 0; e_div = 0; e_mode = 0; e_dir = 0; e_hs = 0;
            e_done = 0; e_out = 0; e_iclk = 1; e_run = 0; e_cnt = 0; e_tc = 0;
        end else begin
            pq.push_front(sclk_in_drv);
            dq.push_front(sdi);
            while (pq.size() > 4) void'(pq.pop_back());
            while (dq.size() > 4) void'(dq.pop_back());
            p2 = (pq.size() > 2) ? pq[2] : 1'b1;
            p3 = (pq.size() > 3) ? pq[3] : 1'b1;
            d2 = (dq.size() > 2) ? dq[2] : 1'b0;
            fe = p3 && !p2;
            re = !p3 && p2;
            acc = (bwr || brd) && baddr == 2'd0;
            cwr = bwr && baddr == 2'd1;
            lim = (e_mode == 2'd3) ? 0 : int'(e_div);
            tick = e_run && (e_tc == lim) && !(acc || cwr);
            sh = (e_mode == 2'd1) ? fe : ((e_mode >= 2'd2) ? (tick && e_iclk) : 1'b0);
            up = (e_mode == 2'd1) ? re : ((e_mode >= 2'd2) ? (tick && !e_iclk) : 1'b0);
            if (acc || cwr) begin
                e_run = acc && (e_mode >= 2'd2); e_iclk = 1; e_tc = 0;
            end else if (tick) begin
                if (!e_iclk && e_done) e_run = 0;
                e_iclk = !e_iclk; e_tc = 0;
            end else if (e_run) e_tc++;
            if (acc) begin
                if (bwr) begin e_sr = bwd; e_out = bwd[7]; end
                e_cnt = 0; e_done = 0;
            end else begin
                old = e_sr[7];
                if (sh) begin
                    e_sr = {e_sr[6:0], d2};
                    if (e_cnt == 7) e_done = 1;
                    e_cnt = (e_cnt + 1) % 8;
                end
                if (up) e_out = old;
            end
            if (cwr) begin e_mode = bwd[1:0]; e_dir = bwd[2]; e_hs = bwd[3]; end
            if (bwr && baddr == 2'd2) e_div = bwd;
        end
    end

    // ---------------- per-clock comparison and edge monitor ----------------
    bit prev_sclk = 1;
    int nfall = 0, lowrun = 0, first_low = 0;
    logic [7:0] cap = 0;

    always @(negedge clk) begin
        logic [7:0] er;
        if (rst_n) begin
            case (baddr)
                2'd0: er = e_sr;
                2'd1: er = {4'b0, e_hs, e_dir, e_mode};
                2'd2: er = e_div;
                default: er = {7'b0, e_done};
            endcase
            chk("R3 rdata", brdata, er);
            chk("R8 sclk_out", sclk_out, e_iclk);
            chk("R4 sdata_out", sdata_out, e_out);
            chk("R5 byte_done", byte_done, e_done);
            chk("R11 hs_out", hs_out, e_done && e_hs);
            chk("R10 sclk_oe", sclk_oe, e_mode[1]);
            chk("R10 sdata_oe", sdata_oe, e_dir);
        end
        if (prev_sclk && !sclk_out) begin nfall++; cap = {cap[6:0], sdata_out}; end
        if (!sclk_out) lowrun++;
        else if (!prev_sclk && first_low == 0) first_low = lowrun;
        if (sclk_out) lowrun = 0;
        prev_sclk = sclk_out;
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1; baddr = a; bwd = d; bwr = 1;
        @(negedge clk); #1; bwr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); #1; baddr = a; brd = 1; #0.5; v = brdata;
        @(negedge clk); #1; brd = 0;
    endtask

    task automatic ext_bit(input logic b, input int half);
        @(negedge clk); #1; sdi = b;
        repeat (half) @(negedge clk);
        #1; sclk_in_drv = 0;
        repeat (half) @(negedge clk);
        #1; sclk_in_drv = 1;
    endtask

    task automatic ext_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) ext_bit(v[i], 3);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(negedge clk); #1; nfall = 0; first_low = 0; cap = 0;
    endtask

    // ---------------- test sequence ----------------
    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        #1; rst_n = 1;
        settle(1);
        // R1 reset state
        chk("R1 sclk_out", sclk_out, 1);
        chk("R1 sdata_out", sdata_out, 0);
        chk("R1 byte_done", byte_done, 0);
        chk("R1 hs_out", hs_out, 0);
        rd_reg(2'd1, v); chk("R1 ctrl", v, 8'h00);
        rd_reg(2'd2, v); chk("R1 div", v, 8'h00);

        // R2 R3 R13: external reception at sysclk/6
        wr_reg(2'd1, 8'h01);
        rd_reg(2'd0, v);
        ext_byte(8'hA5); settle(4);
        rd_reg(2'd3, v); chk("R5 done after eight", v, 1);
        rd_reg(2'd0, v); chk("R13 received byte", v, 8'hA5);
        rd_reg(2'd3, v); chk("R6 read clears done", v, 0);

        // R11 and R9 in external mode
        wr_reg(2'd1, 8'h09);
        rd_reg(2'd0, v);
        ext_byte(8'h3C); settle(4);
        chk("R11 handshake high", hs_out, 1);
        ext_bit(1, 3); ext_bit(0, 3); settle(4);
        chk("R9 ext keeps done", byte_done, 1);
        rd_reg(2'd0, v); chk("R2 two extra bits", v, 8'hF2);
        settle(1);
        chk("R11 handshake cleared", hs_out, 0);

        // R6 restart of the bit count
        wr_reg(2'd1, 8'h01);
        ext_bit(1, 3); ext_bit(1, 3); ext_bit(0, 3);
        wr_reg(2'd0, 8'h00);
        for (int i = 7; i >= 1; i--) ext_bit(v[0] ^ 1'b0 ? 1'b0 : (8'hC3 >> i) & 1, 3);
        settle(4);
        chk("R6 not done after seven", byte_done, 0);
        ext_bit(1, 3); settle(4);
        chk("R6 done after eight", byte_done, 1);
        rd_reg(2'd0, v); chk("R3 msb first", v, 8'hC3);

        // R12 off mode
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h5A);
        ext_byte(8'hFF); settle(4);
        rd_reg(2'd0, v); chk("R12 off mode data", v, 8'h5A);
        chk("R12 off mode done", byte_done, 0);

        // R7 R4: fast mode transmit
        wr_reg(2'd1, 8'h07);
        clear_mon();
        wr_reg(2'd0, 8'h96);
        settle(30);
        chk("R7 falls", nfall, 8);
        chk("R4 fast out", cap, 8'h96);
        chk("R7 half period", first_low, 1);
        chk("R9 fast stop high", sclk_out, 1);
        chk("R10 oe fast", sclk_oe, 1);

        // R8: timer mode transmit with divider 2
        wr_reg(2'd2, 8'h02);
        wr_reg(2'd1, 8'h06);
        clear_mon();
        wr_reg(2'd0, 8'h0F);
        settle(70);
        chk("R8 falls", nfall, 8);
        chk("R8 half period", first_low, 3);
        chk("R4 timer out", cap, 8'h0F);
        chk("R9 timer done", byte_done, 1);
        settle(10);
        chk("R9 timer no extra edges", nfall, 8);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule